// File: doc/BRIEF.md
# Indexed Register Front End for a Display Controller

This block is the register front end of a display controller. Software sees three 32-bit I/O ports. The first port holds a register index. The second port reads and writes the register that the index selects. The third port is an inert stub. The spacing between the ports is a parameter: a stride of 1 gives consecutive offsets and a stride of 4 gives word-spaced offsets.

Behind the index/value pair the block holds the following state:
- an identity register, which accepts only three version-tagged values
- enable and configuration-complete flags
- pending and active display dimensions
- the pixel depth
- a guest identifier
- cursor state
- a small scratch bank

It also answers fixed capability and maximum-dimension queries. Mode writes that fall outside the allowed range are dropped without any side effect. Cursor visibility uses a four-value code: one value shows the cursor, one hides it, and two leave it unchanged. The block emits single-cycle pulses toward the command engine and the cursor path. A separate mode-apply input moves pending dimensions into the active set.

Top module: `ixreg_frontend`

## Requirements
- R1: The index port is at offset 0, the value port at offset IO_STRIDE and the stub port at 2*IO_STRIDE (IO_STRIDE=1 by default). Index-port reads return the last index written. Stub reads return 0 and stub writes change nothing. A read at any other offset returns 0xFFFFFFFF. io_rdata is 0 whenever io_rd is low.
- R2: Index 0 is the identity register. It resets to 0x90000002. A write takes effect only if the value is 0x90000000, 0x90000001 or 0x90000002; any other value leaves it unchanged.
- R3: Index 1 (enable) and index 20 (configuration complete) each become 1 on a nonzero write and 0 on a zero write. They read back as 0 or 1 and drive dev_enable and cfg_done. Index 23 (guest id), 24 (cursor id), 25 (cursor X) and 26 (cursor Y) read back the full 32-bit value last written.
- R4: A width write (index 2) is stored only if the value is at most 2368. A height write (index 3) is stored only if the value is at most 1770. Writes above these limits leave the pending value unchanged.
- R5: A read of width or height returns the pending value when it is nonzero, and otherwise the active value. The active values reset to 640 and 480. A one-cycle mode_apply pulse copies each nonzero pending dimension into the active one.
- R6: Index 6 (depth) reads 24 when the configured pixel depth is 32, and otherwise reads the depth itself. Index 7 (bits per pixel) reads the configured depth, which is 32 by default. Writes to either index have no effect.
- R7: A write to index 27 (cursor visibility) behaves as follows. Value 1 makes the cursor visible and value 0 hides it. Any other value leaves visibility unchanged. The register reads back the visibility as 0 or 1, and cur_vis follows it. Only writes of 0 or 1 raise cur_evt, for exactly the cycle after the write.
- R8: Index 17 (capabilities) reads 0x00000003 when hw_cursor_en is low and 0x000000E3 when it is high. Index 4 reads 2368 and index 5 reads 1770. Writes to indices 4, 5 and 17 have no effect.
- R9: The scratch bank occupies indices 1792 to 1792+SCR_N-1 (SCR_N=8 by default) and reads back what was written there. Index 29 reads SCR_N. Any other unlisted index reads 0 and ignores writes.
- R10: A write to index 21 (sync) raises sync_pulse for exactly the cycle after the write. Index 22 (busy) always reads 0.
- R11: After reset, the following all read 0 or are low: the index, enable, configuration complete, cursor visibility, cur_evt and sync_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Port write strobe, one cycle per access |
| io_rd | input | 1 | Port read strobe; read data is valid in the same cycle |
| io_addr | input | ADDR_W | Port offset |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data |
| hw_cursor_en | input | 1 | Hardware cursor support present |
| mode_apply | input | 1 | Copy nonzero pending dimensions into the active set |
| dev_enable | output | 1 | Enable flag |
| cfg_done | output | 1 | Configuration-complete flag |
| sync_pulse | output | 1 | One-cycle request to the command engine |
| cur_evt | output | 1 | One-cycle cursor update event |
| cur_vis | output | 1 | Cursor visibility |

## Verification
The assertions assume that io_wr and io_rd are never high together, and that every access lasts exactly one cycle. They also assume that hw_cursor_en changes only between accesses. The stimulus respects these limits because it issues each access from a task: the task raises one strobe for a single cycle, drops it, and toggles the capability input only between accesses. The sweeps cover several classes of input:
- port offsets and scratch indices just below, inside and just above the mapped range
- dimension values that straddle each limit
- every visibility code
- both legal and illegal identity values

// File: rtl/ixreg_pkg.sv
package ixreg_pkg;

  localparam logic [31:0] ID_V0 = 32'h9000_0000;
  localparam logic [31:0] ID_V1 = 32'h9000_0001;
  localparam logic [31:0] ID_V2 = 32'h9000_0002;

  localparam logic [31:0] IX_ID       = 32'd0;
  localparam logic [31:0] IX_ENABLE   = 32'd1;
  localparam logic [31:0] IX_WIDTH    = 32'd2;
  localparam logic [31:0] IX_HEIGHT   = 32'd3;
  localparam logic [31:0] IX_MAXW     = 32'd4;
  localparam logic [31:0] IX_MAXH     = 32'd5;
  localparam logic [31:0] IX_DEPTH    = 32'd6;
  localparam logic [31:0] IX_BPP      = 32'd7;
  localparam logic [31:0] IX_CAPS     = 32'd17;
  localparam logic [31:0] IX_CFGDONE  = 32'd20;
  localparam logic [31:0] IX_SYNC     = 32'd21;
  localparam logic [31:0] IX_BUSY     = 32'd22;
  localparam logic [31:0] IX_GUEST    = 32'd23;
  localparam logic [31:0] IX_CUR_ID   = 32'd24;
  localparam logic [31:0] IX_CUR_X    = 32'd25;
  localparam logic [31:0] IX_CUR_Y    = 32'd26;
  localparam logic [31:0] IX_CUR_ON   = 32'd27;
  localparam logic [31:0] IX_SCR_SIZE = 32'd29;
  localparam int unsigned SCR_BASE    = 1792;

  localparam logic [31:0] CAP_BASE   = 32'h0000_0003;
  localparam logic [31:0] CAP_CURSOR = 32'h0000_00E0;

  typedef enum logic [1:0] {
    PSEL_INDEX,
    PSEL_VALUE,
    PSEL_STUB,
    PSEL_NONE
  } port_sel_e;

  function automatic logic id_legal(input logic [31:0] v);
    return (v == ID_V0) || (v == ID_V1) || (v == ID_V2);
  endfunction

endpackage

// File: rtl/ixreg_portdec.sv
module ixreg_portdec
  import ixreg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned IO_STRIDE = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output port_sel_e         sel
);
  localparam logic [ADDR_W-1:0] OFS_INDEX = '0;
  localparam logic [ADDR_W-1:0] OFS_VALUE = ADDR_W'(IO_STRIDE);
  localparam logic [ADDR_W-1:0] OFS_STUB  = ADDR_W'(2 * IO_STRIDE);

  always_comb begin
    if (addr == OFS_INDEX)      sel = PSEL_INDEX;
    else if (addr == OFS_VALUE) sel = PSEL_VALUE;
    else if (addr == OFS_STUB)  sel = PSEL_STUB;
    else                        sel = PSEL_NONE;
  end
endmodule

// File: rtl/ixreg_mode.sv
module ixreg_mode #(
  parameter int unsigned MAX_W     = 2368,
  parameter int unsigned MAX_H     = 1770,
  parameter int unsigned ACT_W_RST = 640,
  parameter int unsigned ACT_H_RST = 480,
  parameter int unsigned DEPTH     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_w,
  input  logic        wr_h,
  input  logic        apply,
  input  logic [31:0] wdata,
  output logic [31:0] rd_w,
  output logic [31:0] rd_h,
  output logic [31:0] rd_depth,
  output logic [31:0] rd_bpp
);
  localparam int unsigned DIM_MAX = (MAX_W > MAX_H) ? MAX_W : MAX_H;
  localparam int unsigned DIM_W   = $clog2(DIM_MAX + 1);
  localparam int unsigned PAD_W   = 32 - DIM_W;

  logic [DIM_W-1:0] pend_w_q, pend_w_d, pend_h_q, pend_h_d;
  logic [DIM_W-1:0] act_w_q, act_w_d, act_h_q, act_h_d;
  logic             w_ok, h_ok;

  assign w_ok = (wdata <= 32'(MAX_W));
  assign h_ok = (wdata <= 32'(MAX_H));

  always_comb begin
    pend_w_d = pend_w_q;
    pend_h_d = pend_h_q;
    act_w_d  = act_w_q;
    act_h_d  = act_h_q;
    if (wr_w && w_ok) pend_w_d = wdata[DIM_W-1:0];
    if (wr_h && h_ok) pend_h_d = wdata[DIM_W-1:0];
    if (apply) begin
      if (pend_w_q != '0) act_w_d = pend_w_q;
      if (pend_h_q != '0) act_h_d = pend_h_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_w_q <= '0;
      pend_h_q <= '0;
      act_w_q  <= DIM_W'(ACT_W_RST);
      act_h_q  <= DIM_W'(ACT_H_RST);
    end else begin
      pend_w_q <= pend_w_d;
      pend_h_q <= pend_h_d;
      act_w_q  <= act_w_d;
      act_h_q  <= act_h_d;
    end
  end

  assign rd_w     = {{PAD_W{1'b0}}, (pend_w_q != '0) ? pend_w_q : act_w_q};
  assign rd_h     = {{PAD_W{1'b0}}, (pend_h_q != '0) ? pend_h_q : act_h_q};
  assign rd_depth = (DEPTH == 32) ? 32'd24 : 32'(DEPTH);
  assign rd_bpp   = 32'(DEPTH);

  AST_WIDTH_BOUND:  assert property (@(posedge clk) disable iff (!rst_n)
    32'(pend_w_q) <= 32'(MAX_W)); // R4
  AST_HEIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pend_h_q) <= 32'(MAX_H)); // R4
  AST_WIDTH_KEEP:   assert property (@(posedge clk) disable iff (!rst_n)
    (wr_w && !w_ok) |=> $stable(pend_w_q)); // R4
  AST_ACT_NONZERO:  assert property (@(posedge clk) disable iff (!rst_n)
    (act_w_q != '0) && (act_h_q != '0)); // R5
endmodule

// File: rtl/ixreg_cursor.sv
module ixreg_cursor (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_id,
  input  logic        wr_x,
  input  logic        wr_y,
  input  logic        wr_on,
  input  logic [31:0] wdata,
  output logic [31:0] cur_id,
  output logic [31:0] cur_x,
  output logic [31:0] cur_y,
  output logic        vis,
  output logic        evt
);
  logic [31:0] id_d, x_d, y_d;
  logic        vis_d, evt_d, code_hit;

  assign code_hit = (wdata[31:1] == '0);

  always_comb begin
    id_d  = wr_id ? wdata : cur_id;
    x_d   = wr_x  ? wdata : cur_x;
    y_d   = wr_y  ? wdata : cur_y;
    vis_d = vis;
    if (wr_on && code_hit) vis_d = wdata[0];
    evt_d = wr_on && code_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_id <= '0;
      cur_x  <= '0;
      cur_y  <= '0;
      vis    <= 1'b0;
      evt    <= 1'b0;
    end else begin
      cur_id <= id_d;
      cur_x  <= x_d;
      cur_y  <= y_d;
      vis    <= vis_d;
      evt    <= evt_d;
    end
  end

  AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_on && (wdata > 32'd1)) |=> $stable(vis)); // R7
  AST_CUR_EVT:  assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (vis == $past(wdata[0]))); // R7
endmodule

// File: rtl/ixreg_scratch.sv
module ixreg_scratch #(
  parameter int unsigned BASE  = 1792,
  parameter int unsigned SCR_N = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] idx,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic        hit,
  output logic [31:0] rdata
);
  logic [SCR_N-1:0] sel;
  logic [31:0]      bank_q [SCR_N];

  for (genvar g = 0; g < SCR_N; g++) begin : g_ent
    logic [31:0] ent_d;
    assign sel[g] = (idx == 32'(BASE + g));
    assign ent_d  = (wr && sel[g]) ? wdata : bank_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[g] <= '0;
      else        bank_q[g] <= ent_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < SCR_N; i++) begin
      if (sel[i]) rdata = rdata | bank_q[i];
    end
  end

  assign hit = |sel;

  AST_SCR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R9
endmodule

// File: rtl/ixreg_frontend.sv
module ixreg_frontend
  import ixreg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned IO_STRIDE = 1,
  parameter int unsigned SCR_N     = 8,
  parameter int unsigned MAX_W     = 2368,
  parameter int unsigned MAX_H     = 1770,
  parameter int unsigned DEPTH     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [31:0]       io_wdata,
  output logic [31:0]       io_rdata,
  input  logic              hw_cursor_en,
  input  logic              mode_apply,
  output logic              dev_enable,
  output logic              cfg_done,
  output logic              sync_pulse,
  output logic              cur_evt,
  output logic              cur_vis
);
  port_sel_e   psel;
  logic        val_wr;
  logic [31:0] idx_q, idx_d, id_q, id_d, guest_q, guest_d;
  logic        en_d, cfg_d, sync_d;
  logic [31:0] m_w, m_h, m_depth, m_bpp;
  logic [31:0] c_id, c_x, c_y;
  logic        scr_hit;
  logic [31:0] scr_rdata, val_rdata, port_rdata;

  ixreg_portdec #(.ADDR_W(ADDR_W), .IO_STRIDE(IO_STRIDE)) u_dec (
    .addr(io_addr), .sel(psel));

  assign val_wr = io_wr && (psel == PSEL_VALUE);

  ixreg_mode #(.MAX_W(MAX_W), .MAX_H(MAX_H), .DEPTH(DEPTH)) u_mode (
    .clk(clk), .rst_n(rst_n),
    .wr_w(val_wr && (idx_q == IX_WIDTH)),
    .wr_h(val_wr && (idx_q == IX_HEIGHT)),
    .apply(mode_apply), .wdata(io_wdata),
    .rd_w(m_w), .rd_h(m_h), .rd_depth(m_depth), .rd_bpp(m_bpp));

  ixreg_cursor u_cur (
    .clk(clk), .rst_n(rst_n),
    .wr_id(val_wr && (idx_q == IX_CUR_ID)),
    .wr_x(val_wr && (idx_q == IX_CUR_X)),
    .wr_y(val_wr && (idx_q == IX_CUR_Y)),
    .wr_on(val_wr && (idx_q == IX_CUR_ON)),
    .wdata(io_wdata),
    .cur_id(c_id), .cur_x(c_x), .cur_y(c_y), .vis(cur_vis), .evt(cur_evt));

  ixreg_scratch #(.BASE(SCR_BASE), .SCR_N(SCR_N)) u_scr (
    .clk(clk), .rst_n(rst_n), .idx(idx_q), .wr(val_wr), .wdata(io_wdata),
    .hit(scr_hit), .rdata(scr_rdata));

  always_comb begin
    idx_d   = (io_wr && (psel == PSEL_INDEX)) ? io_wdata : idx_q;
    id_d    = id_q;
    en_d    = dev_enable;
    cfg_d   = cfg_done;
    guest_d = guest_q;
    sync_d  = 1'b0;
    if (val_wr) begin
      unique case (idx_q)
        IX_ID:      if (id_legal(io_wdata)) id_d = io_wdata;
        IX_ENABLE:  en_d    = (io_wdata != '0);
        IX_CFGDONE: cfg_d   = (io_wdata != '0);
        IX_GUEST:   guest_d = io_wdata;
        IX_SYNC:    sync_d  = 1'b1;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      id_q       <= ID_V2;
      dev_enable <= 1'b0;
      cfg_done   <= 1'b0;
      guest_q    <= '0;
      sync_pulse <= 1'b0;
    end else begin
      idx_q      <= idx_d;
      id_q       <= id_d;
      dev_enable <= en_d;
      cfg_done   <= cfg_d;
      guest_q    <= guest_d;
      sync_pulse <= sync_d;
    end
  end

  always_comb begin
    case (idx_q)
      IX_ID:       val_rdata = id_q;
      IX_ENABLE:   val_rdata = {31'd0, dev_enable};
      IX_WIDTH:    val_rdata = m_w;
      IX_HEIGHT:   val_rdata = m_h;
      IX_MAXW:     val_rdata = 32'(MAX_W);
      IX_MAXH:     val_rdata = 32'(MAX_H);
      IX_DEPTH:    val_rdata = m_depth;
      IX_BPP:      val_rdata = m_bpp;
      IX_CAPS:     val_rdata = CAP_BASE | (hw_cursor_en ? CAP_CURSOR : '0);
      IX_CFGDONE:  val_rdata = {31'd0, cfg_done};
      IX_BUSY:     val_rdata = '0;
      IX_GUEST:    val_rdata = guest_q;
      IX_CUR_ID:   val_rdata = c_id;
      IX_CUR_X:    val_rdata = c_x;
      IX_CUR_Y:    val_rdata = c_y;
      IX_CUR_ON:   val_rdata = {31'd0, cur_vis};
      IX_SCR_SIZE: val_rdata = 32'(SCR_N);
      default:     val_rdata = scr_hit ? scr_rdata : '0;
    endcase
  end

  always_comb begin
    unique case (psel)
      PSEL_INDEX: port_rdata = idx_q;
      PSEL_VALUE: port_rdata = val_rdata;
      PSEL_STUB:  port_rdata = '0;
      default:    port_rdata = '1;
    endcase
  end

  assign io_rdata = io_rd ? port_rdata : '0;

  AST_ID_LEGAL:      assert property (@(posedge clk) disable iff (!rst_n)
    id_legal(id_q)); // R2
  AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (psel == PSEL_NONE)) |-> (io_rdata == 32'hFFFF_FFFF)); // R1
  AST_SYNC_SRC:      assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> $past(io_wr && (psel == PSEL_VALUE))); // R10
  AST_STUB_KEEP_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && (psel == PSEL_STUB)) |=> $stable(idx_q)); // R1
endmodule

// File: tb/ixreg_frontend_test.sv
module ixreg_frontend_test;
  localparam int unsigned STRIDE = 1;
  localparam int unsigned NSCR   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [3:0]  io_addr = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        hw_cursor_en = 1'b0, mode_apply = 1'b0;
  logic        dev_enable, cfg_done, sync_pulse, cur_evt, cur_vis;

  int n_chk = 0, n_bad = 0;
  logic evt_seen, sync_seen;

  always #2 clk = ~clk;

  ixreg_frontend uut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .hw_cursor_en(hw_cursor_en),
    .mode_apply(mode_apply), .dev_enable(dev_enable), .cfg_done(cfg_done),
    .sync_pulse(sync_pulse), .cur_evt(cur_evt), .cur_vis(cur_vis));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic port_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
    evt_seen  = cur_evt;
    sync_seen = sync_pulse;
  endtask

  task automatic port_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [31:0] ix, input logic [31:0] d);
    port_wr(4'd0, ix);
    port_wr(4'(STRIDE), d);
  endtask

  task automatic reg_rd(input logic [31:0] ix, output logic [31:0] d);
    port_wr(4'd0, ix);
    port_rd(4'(STRIDE), d);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r, exp_id, pend, act;
    logic        vis;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    port_rd(4'd0, r);                chk("R11", "index", r, 32'd0);
    chk("R11", "enable", {31'd0, dev_enable}, 32'd0);
    chk("R11", "cfg", {31'd0, cfg_done}, 32'd0);
    chk("R11", "vis", {31'd0, cur_vis}, 32'd0);
    chk("R11", "pulses", {30'd0, sync_pulse, cur_evt}, 32'd0);
    reg_rd(32'd0, r);                chk("R2", "id reset", r, 32'h9000_0002);

    // R1 offset sweep
    port_wr(4'd0, 32'd1234);
    for (int a = 0; a < 16; a++) begin
      port_rd(4'(a), r);
      if (a == 0)                chk("R1", "index port", r, 32'd1234);
      else if (a == STRIDE)      chk("R1", "value port unknown", r, 32'd0);
      else if (a == 2 * STRIDE)  chk("R1", "stub read", r, 32'd0);
      else                       chk("R1", "unmapped", r, 32'hFFFF_FFFF);
    end
    port_wr(4'(2 * STRIDE), 32'd77);
    port_rd(4'd0, r);                chk("R1", "stub write keeps index", r, 32'd1234);
    @(negedge clk); #1;              chk("R1", "rdata idle", io_rdata, 32'd0);

    // R2 identity sweep
    exp_id = 32'h9000_0002;
    for (int i = 0; i < 6; i++) begin
      logic [31:0] v;
      v = (i < 4) ? (32'h9000_0000 + 32'(i)) : ((i == 4) ? 32'h1234_5678 : 32'h9000_0100);
      if (v == 32'h9000_0000 || v == 32'h9000_0001 || v == 32'h9000_0002) exp_id = v;
      reg_wr(32'd0, v);
      reg_rd(32'd0, r);              chk("R2", "id write", r, exp_id);
    end

    // R3 flags and plain registers
    reg_wr(32'd1, 32'd5);            chk("R3", "dev_enable", {31'd0, dev_enable}, 32'd1);
    reg_rd(32'd1, r);                chk("R3", "enable read", r, 32'd1);
    reg_wr(32'd1, 32'd0);            chk("R3", "dev_enable off", {31'd0, dev_enable}, 32'd0);
    reg_wr(32'd20, 32'h100);         chk("R3", "cfg_done", {31'd0, cfg_done}, 32'd1);
    for (int k = 23; k <= 26; k++) begin
      reg_wr(32'(k), 32'hA5A5_0000 + 32'(k));
      reg_rd(32'(k), r);             chk("R3", "readback", r, 32'hA5A5_0000 + 32'(k));
    end

    // R4/R5 width sweep
    act = 32'd640; pend = 32'd0;
    for (int i = 0; i < 7; i++) begin
      logic [31:0] v;
      case (i)
        0: v = 32'd0;   1: v = 32'd1;   2: v = 32'd2367; 3: v = 32'd2368;
        4: v = 32'd2369; 5: v = 32'd4095; default: v = 32'hFFFF_FFFF;
      endcase
      if (v <= 32'd2368) pend = v;
      reg_wr(32'd2, v);
      reg_rd(32'd2, r);              chk("R4", "width", r, (pend != 0) ? pend : act);
    end
    @(negedge clk); mode_apply = 1'b1;
    @(negedge clk); mode_apply = 1'b0;
    reg_wr(32'd2, 32'd0);
    reg_rd(32'd2, r);                chk("R5", "active width", r, 32'd2368);
    // height sweep
    reg_rd(32'd3, r);                chk("R5", "height default", r, 32'd480);
    act = 32'd480; pend = 32'd0;
    for (int i = 0; i < 5; i++) begin
      logic [31:0] v;
      v = 32'd1768 + 32'(i);
      if (v <= 32'd1770) pend = v;
      reg_wr(32'd3, v);
      reg_rd(32'd3, r);              chk("R4", "height", r, (pend != 0) ? pend : act);
    end

    // R6 depth
    reg_wr(32'd6, 32'd8);  reg_rd(32'd6, r); chk("R6", "depth", r, 32'd24);
    reg_wr(32'd7, 32'd16); reg_rd(32'd7, r); chk("R6", "bpp", r, 32'd32);

    // R7 visibility codes
    vis = 1'b0;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = 32'((i * 5 + 1) % 4);
      if (i == 7) v = 32'd9;
      if (v == 1) vis = 1'b1;
      if (v == 0) vis = 1'b0;
      reg_wr(32'd27, v);
      chk("R7", "evt", {31'd0, evt_seen}, {31'd0, v <= 1});
      chk("R7", "vis", {31'd0, cur_vis}, {31'd0, vis});
      @(negedge clk);
      chk("R7", "evt drops", {31'd0, cur_evt}, 32'd0);
    end
    reg_rd(32'd27, r);               chk("R7", "vis read", r, {31'd0, vis});

    // R8 fixed values
    reg_wr(32'd17, 32'd0);
    reg_rd(32'd17, r);               chk("R8", "caps no cursor", r, 32'h3);
    hw_cursor_en = 1'b1;
    port_rd(4'(STRIDE), r);          chk("R8", "caps cursor", r, 32'hE3);
    hw_cursor_en = 1'b0;
    reg_wr(32'd4, 32'd1);
    reg_rd(32'd4, r);                chk("R8", "max width", r, 32'd2368);
    reg_rd(32'd5, r);                chk("R8", "max height", r, 32'd1770);

    // R9 scratch sweep
    for (int k = 1790; k < 1792 + NSCR + 2; k++) reg_wr(32'(k), 32'(k) * 3 + 7);
    for (int k = 1790; k < 1792 + NSCR + 2; k++) begin
      reg_rd(32'(k), r);
      chk("R9", "scratch", r, (k >= 1792 && k < 1792 + NSCR) ? 32'(k) * 3 + 7 : 32'd0);
    end
    reg_rd(32'd29, r);               chk("R9", "scratch size", r, 32'(NSCR));

    // R10 sync
    reg_wr(32'd21, 32'd1);           chk("R10", "sync pulse", {31'd0, sync_seen}, 32'd1);
    @(negedge clk);                  chk("R10", "sync drops", {31'd0, sync_pulse}, 32'd0);
    reg_rd(32'd22, r);               chk("R10", "busy", r, 32'd0);

    finish_run();
  end
endmodule